// File: doc/BRIEF.md
# Multi-Step Calibration Sequencer

This block runs a converter's calibration once a start bit is set. A captured mode bit chooses between internal (self) calibration and system calibration. A captured 2-bit selector chooses which steps run and in what order. There are three possible steps: reference-DAC trim, gain trim and offset trim. The sequencer does not do any of the analog work or coefficient arithmetic itself. For each step it raises a one-hot request towards an external calibration engine, together with a flag that says whether the step uses system inputs. It then holds that request until the engine returns a one-cycle done pulse.

When the last step's done pulse arrives, the sequencer emits a one-cycle completion pulse. The control register uses this pulse to clear its start bit. There is no data stream. The request/done pair is the only handshake, and it has no back-pressure beyond the engine holding off its done pulse: a request stays asserted for as long as the engine needs. All other pins are plain levels.

Top module: `cal_seq`

## Requirements
- R1: After reset, `busy_o` is 0, `step_req_o` is 0 and `cal_done_o` is 0.
- R2: When `start_i` is 1 while idle, `busy_o` is 1 from the next cycle and the first step's request is present in that same cycle.
- R3: Select 2'b00 runs three steps in order: DAC (`step_req_o` = 3'b001), then gain (3'b010), then offset (3'b100).
- R4: Select 2'b01 runs gain (3'b010), then offset (3'b100).
- R5: Select 2'b10 runs offset (3'b100) only. Select 2'b11 runs gain (3'b010) only.
- R6: `step_sys_o` is 1 during gain and offset steps when the captured mode is 1 (system). It is 0 in mode 0 (self) and always 0 during the DAC step.
- R7: `step_req_o` is one-hot while busy. A step's request holds unchanged until `step_done_i` is 1, and the next step's request appears in the following cycle.
- R8: The done pulse of the final step makes `cal_done_o` 1 for exactly one cycle. `busy_o` falls in that same cycle.
- R9: A `start_i` that arrives while busy is ignored. Mode and select are captured at acceptance, so later changes to `mode_i` and `sel_i` do not alter a running sequence.
- R10: A `step_done_i` pulse while idle has no effect: `busy_o` and `step_req_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Calibration start bit from the control register |
| mode_i | input | 1 | 0 = self calibration, 1 = system calibration |
| sel_i | input | 2 | Step-list selector |
| step_done_i | input | 1 | One-cycle pulse: current step finished |
| busy_o | output | 1 | Sequence in progress |
| step_req_o | output | 3 | One-hot step request: bit0 DAC, bit1 gain, bit2 offset |
| step_sys_o | output | 1 | Current step uses system inputs |
| cal_done_o | output | 1 | One-cycle completion pulse; clears the start bit |

## Verification
The following are checked on every cycle:
- the request is one-hot and tied to busy;
- a request holds still until its done pulse arrives;
- the DAC step never carries the system flag;
- completion is a single pulse that coincides with busy falling;
- an idle start always leads to busy.

The exact order of steps for each selector and mode can only be shown by the bench's scenarios. The same applies to ignoring a start while busy, to the capture of mode and select, and to ignoring a stray done pulse while idle.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  localparam int STEP_W    = 2;
  localparam int MAX_STEPS = 3;
  localparam int KINDS     = 3;
  localparam int IDX_W     = $clog2(MAX_STEPS + 1);

  localparam logic [STEP_W-1:0] STEP_DAC  = 2'd0;
  localparam logic [STEP_W-1:0] STEP_GAIN = 2'd1;
  localparam logic [STEP_W-1:0] STEP_OFFS = 2'd2;

  typedef struct packed {
    logic [IDX_W-1:0]                    len;
    logic [MAX_STEPS-1:0][STEP_W-1:0]    seq;
  } plan_t;
endpackage

// File: rtl/cal_seq_plan.sv
module cal_seq_plan
  import cal_seq_pkg::*;
(
  input  logic [1:0] sel_i,
  output plan_t      plan_o
);
  always_comb begin
    plan_o = '0;
    unique case (sel_i)
      2'b00: begin
        plan_o.len    = IDX_W'(3);
        plan_o.seq[0] = STEP_DAC;
        plan_o.seq[1] = STEP_GAIN;
        plan_o.seq[2] = STEP_OFFS;
      end
      2'b01: begin
        plan_o.len    = IDX_W'(2);
        plan_o.seq[0] = STEP_GAIN;
        plan_o.seq[1] = STEP_OFFS;
      end
      2'b10: begin
        plan_o.len    = IDX_W'(1);
        plan_o.seq[0] = STEP_OFFS;
      end
      default: begin
        plan_o.len    = IDX_W'(1);
        plan_o.seq[0] = STEP_GAIN;
      end
    endcase
  end
endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
  import cal_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  plan_t             plan_i,
  input  logic              step_done_i,
  output logic              busy_o,
  output logic              mode_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o
);
  plan_t            plan_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q, mode_q, done_q;
  logic             last_step;

  assign last_step = (idx_q + IDX_W'(1)) == plan_q.len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plan_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          plan_q <= plan_i;
          mode_q <= mode_i;
          idx_q  <= '0;
        end
      end else if (step_done_i) begin
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign mode_o = mode_q;
  assign done_o = done_q;
  assign step_o = (idx_q < IDX_W'(MAX_STEPS)) ? plan_q.seq[idx_q[$clog2(MAX_STEPS)-1:0]] : STEP_DAC;
endmodule

// File: rtl/cal_seq_reqdec.sv
module cal_seq_reqdec
  import cal_seq_pkg::*;
(
  input  logic              busy_i,
  input  logic              mode_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [KINDS-1:0]  req_o,
  output logic              sys_o
);
  for (genvar k = 0; k < KINDS; k++) begin : g_req
    assign req_o[k] = busy_i && (step_i == STEP_W'(k));
  end
  assign sys_o = busy_i && mode_i && (step_i != STEP_DAC);
endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [1:0]       sel_i,
  input  logic             step_done_i,
  output logic             busy_o,
  output logic [KINDS-1:0] step_req_o,
  output logic             step_sys_o,
  output logic             cal_done_o
);
  plan_t             plan;
  logic              run_mode;
  logic [STEP_W-1:0] cur_step;

  cal_seq_plan u_plan (
    .sel_i  (sel_i),
    .plan_o (plan)
  );

  cal_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .plan_i      (plan),
    .step_done_i (step_done_i),
    .busy_o      (busy_o),
    .mode_o      (run_mode),
    .step_o      (cur_step),
    .done_o      (cal_done_o)
  );

  cal_seq_reqdec u_dec (
    .busy_i (busy_o),
    .mode_i (run_mode),
    .step_i (cur_step),
    .req_o  (step_req_o),
    .sys_o  (step_sys_o)
  );
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       step_done_i,
  input logic       busy_o,
  input logic [2:0] step_req_o,
  input logic       step_sys_o,
  input logic       cal_done_o
);
  p_req_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $onehot(step_req_o));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (step_req_o == 3'b000 && !step_sys_o));
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_done_i) |=> ($stable(step_req_o) && $stable(step_sys_o)));
  p_dac_internal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o[0] |-> !step_sys_o);
  p_done_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |-> (!busy_o && $past(busy_o)));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |=> !cal_done_o);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);
endmodule

bind cal_seq cal_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .step_done_i (step_done_i),
  .busy_o      (busy_o),
  .step_req_o  (step_req_o),
  .step_sys_o  (step_sys_o),
  .cal_done_o  (cal_done_o)
);

// File: tb/cal_seq_test.sv
module cal_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  // {mode, sel, len, s0, s1, s2}; step code 0 DAC, 1 gain, 2 offset
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'b00, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b0, 2'b01, 2'd2, 2'd1, 2'd2, 2'd0},
    {1'b0, 2'b10, 2'd1, 2'd2, 2'd0, 2'd0},
    {1'b0, 2'b11, 2'd1, 2'd1, 2'd0, 2'd0},
    {1'b1, 2'b00, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b1, 2'b01, 2'd2, 2'd1, 2'd2, 2'd0},
    {1'b1, 2'b10, 2'd1, 2'd2, 2'd0, 2'd0},
    {1'b1, 2'b11, 2'd1, 2'd1, 2'd0, 2'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [1:0] sel_i = 2'b00;
  logic       step_done_i = 1'b0;
  logic       busy_o;
  logic [2:0] step_req_o;
  logic       step_sys_o;
  logic       cal_done_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_seq uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .sel_i       (sel_i),
    .step_done_i (step_done_i),
    .busy_o      (busy_o),
    .step_req_o  (step_req_o),
    .step_sys_o  (step_sys_o),
    .cal_done_o  (cal_done_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 req", int'(step_req_o), 0);
    chk("R1 done", int'(cal_done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic       m;
      logic [1:0] s;
      int         len;
      string      tag;
      m   = VEC[v][10];
      s   = VEC[v][9:8];
      len = int'(VEC[v][7:6]);
      tag = (s == 2'b00) ? "R3" : (s == 2'b01) ? "R4" : "R5";
      mode_i = m; sel_i = s; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R2 busy", int'(busy_o), 1);
      for (int k = 0; k < len; k++) begin
        logic [1:0] code;
        int         exp_req;
        int         exp_sys;
        code    = VEC[v][5 - 2*k -: 2];
        exp_req = 1 << code;
        exp_sys = (m && code != 2'd0) ? 1 : 0;
        chk(tag, int'(step_req_o), exp_req);
        chk("R6 sys", int'(step_sys_o), exp_sys);
        @(negedge clk);
        chk("R7 hold", int'(step_req_o), exp_req);
        step_done_i = 1'b1;
        @(negedge clk);
        step_done_i = 1'b0;
      end
      chk("R8 done", int'(cal_done_o), 1);
      chk("R8 busy", int'(busy_o), 0);
      @(negedge clk);
      chk("R8 pulse", int'(cal_done_o), 0);
    end

    // R9: start during a run is ignored, capture holds
    mode_i = 1'b0; sel_i = 2'b10; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b1; mode_i = 1'b1; sel_i = 2'b00;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 req", int'(step_req_o), 4);
    chk("R9 sys", int'(step_sys_o), 0);
    step_done_i = 1'b1;
    @(negedge clk);
    step_done_i = 1'b0;
    chk("R9 done", int'(cal_done_o), 1);
    @(negedge clk);
    chk("R9 idle", int'(busy_o), 0);

    // R10: stray done pulse while idle
    step_done_i = 1'b1;
    @(negedge clk);
    step_done_i = 1'b0;
    @(negedge clk);
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 req", int'(step_req_o), 0);
    chk("R10 done", int'(cal_done_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule